// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level page table from memory, starting at a root base register. Each walk reads the directory entry first and then the table entry, one word at a time, over a synchronous memory port. The walker checks each access against the permission bits of both entries, the access type and the current privilege ring. It sets the accessed and dirty bits of the final entry with a read-modify-write. It then returns either the physical address or a fault with a cause code.

A requester presents an address, a write flag and its ring while `req_ready` is high. Exactly one walk is in flight at a time. The result appears for one cycle on the response outputs. Ring 0 software loads the root base through the same privilege input while the walker is idle.

The reset input `rst_n` is asynchronous on assertion and is expected to be released in step with `clk`.

Top module: `pt_walk_unit`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and the root base is 0.
- R2: A walk first reads the word at root + linear[31:22]×4 and then the word at (directory entry[31:12]<<12) + linear[21:12]×4. Every memory address is word aligned.
- R3: On success, `rsp_paddr` is {table entry[31:12], linear[11:0]} and `rsp_cause` is 0. On any fault, `rsp_paddr` is 0 and `rsp_fault` is 1.
- R4: Entry flag bit 0 is the present bit. A clear present bit in the directory entry ends the walk with cause 1, and no table read is made. A clear present bit in the table entry gives cause 2.
- R5: Flag bit 1 is writable. A write access faults with cause 3 if this bit is clear in either entry, at every ring.
- R6: Flag bit 2 is user. A ring 3 access faults with cause 4 if this bit is clear in either entry. Rings 0 to 2 skip this check. Cause 2 ranks above cause 4, and cause 4 ranks above cause 3.
- R7: On a successful walk, the table entry gets flag bit 5 (accessed) set, and also flag bit 6 (dirty) if the access is a write. It is written back to the address it was read from, and only if its value changed. A faulting walk writes nothing.
- R8: All other entry bits are kept as they are in the write-back and do not affect translation. This includes the software bits 11:9.
- R9: The root base loads only when `root_load` is high, `cpl` is 0 and the walker is idle. Bits 11:0 of the loaded value are forced to 0.
- R10: `req_ready` is high only in the idle state and drops the cycle after a request is taken. `rsp_valid` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpl | input | 2 | Current privilege ring, for root loads and requests |
| root_load | input | 1 | Request to load the root base |
| root_wdata | input | 32 | New root base value |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read strobe |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 3 | 0 none, 1 directory not present, 2 table not present, 3 write protection, 4 privilege |
| rsp_paddr | output | 32 | Physical address |

## Verification
The assertions assume a memory that returns read data exactly one cycle after each read strobe. They also assume that `req_valid` is raised only while the walker can take it. The bench's memory model registers read data on the strobe edge and updates its array on writes. The bench raises requests only after it sees `req_ready` high. It loads the root base while a walk is running only on purpose, to show that such a load is ignored. The table contents are chosen so that every walk stays inside the modelled 16 KB physical window.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry flag bit positions
  localparam int FLAG_PRESENT  = 0;
  localparam int FLAG_WRITE    = 1;
  localparam int FLAG_USER     = 2;
  localparam int FLAG_ACCESSED = 5;
  localparam int FLAG_DIRTY    = 6;

  localparam logic [1:0] RING_KERNEL = 2'd0;
  localparam logic [1:0] RING_USER   = 2'd3;

  localparam int CAUSE_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READ_DIR = 3'd1,
    ST_READ_PTE = 3'd2,
    ST_UPDATE   = 3'd3,
    ST_DONE     = 3'd4
  } walk_state_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_DIR_NP = 3'd1,
    CAUSE_TBL_NP = 3'd2,
    CAUSE_WPROT  = 3'd3,
    CAUSE_PRIV   = 3'd4
  } fault_cause_e;

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walker_idle,
  input  logic [1:0]        cpl,
  input  logic              load_req,
  input  logic [ADDR_W-1:0] load_data,
  output logic [ADDR_W-1:0] root_q
);

  localparam logic [ADDR_W-1:0] FRAME_MASK = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic              load_en;
  logic [ADDR_W-1:0] root_d;

  // Loading is a ring 0 privilege and is only allowed between walks
  assign load_en = load_req && walker_idle && (cpl == RING_KERNEL);

  always_comb begin
    root_d = root_q;
    if (load_en) begin
      root_d = load_data & FRAME_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
    end else begin
      root_q <= root_d;
    end
  end

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              dir_write,
  input  logic              dir_user,
  input  logic [ADDR_W-1:0] tbl_entry,
  input  logic              is_write,
  input  logic              is_user,
  output fault_cause_e      cause,
  output logic [ADDR_W-1:0] upd_entry,
  output logic              upd_needed
);

  logic              user_ok;
  logic              write_ok;
  logic [ADDR_W-1:0] set_mask;

  assign user_ok  = dir_user && tbl_entry[FLAG_USER];
  assign write_ok = dir_write && tbl_entry[FLAG_WRITE];

  // Bits that the hardware sets in the final entry
  for (genvar b = 0; b < ADDR_W; b++) begin : g_set_mask
    if (b == FLAG_ACCESSED) begin : g_acc
      assign set_mask[b] = 1'b1;
    end else if (b == FLAG_DIRTY) begin : g_dirty
      assign set_mask[b] = is_write;
    end else begin : g_keep
      assign set_mask[b] = 1'b0;
    end
  end

  // Ranking: table not present, then privilege, then write protection
  always_comb begin
    cause = CAUSE_NONE;
    if (!tbl_entry[FLAG_PRESENT]) begin
      cause = CAUSE_TBL_NP;
    end else if (is_user && !user_ok) begin
      cause = CAUSE_PRIV;
    end else if (is_write && !write_ok) begin
      cause = CAUSE_WPROT;
    end
  end

  assign upd_entry  = tbl_entry | set_mask;
  assign upd_needed = (upd_entry != tbl_entry);

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DIR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] root_q,
  input  logic [1:0]        cpl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr
);

  localparam int TBL_W   = ADDR_W - OFF_W - DIR_W;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int ENT_LG  = 2;

  walk_state_e        state_q, state_d;
  logic               pend_q, pend_d;
  logic [ADDR_W-1:0]  va_q;
  logic               wr_q;
  logic               user_q;
  logic [FRAME_W-1:0] dfr_q;
  logic               dw_q;
  logic               du_q;
  logic [ADDR_W-1:0]  tent_q, tent_d;
  fault_cause_e       cause_q, cause_d;

  logic               cap_req;
  logic               dir_cap;
  logic               tbl_cap;
  logic               cause_en;

  fault_cause_e       eval_cause;
  logic [ADDR_W-1:0]  eval_upd;
  logic               eval_needed;

  logic [DIR_W-1:0]   dir_idx;
  logic [TBL_W-1:0]   tbl_idx;
  logic [ADDR_W-1:0]  dir_addr;
  logic [ADDR_W-1:0]  tbl_addr;
  logic               dir_bits_unused;

  assign dir_idx  = va_q[ADDR_W-1 -: DIR_W];
  assign tbl_idx  = va_q[OFF_W +: TBL_W];
  assign dir_addr = root_q + {{(ADDR_W-DIR_W-ENT_LG){1'b0}}, dir_idx, {ENT_LG{1'b0}}};
  assign tbl_addr = {dfr_q, {OFF_W{1'b0}}}
                  + {{(ADDR_W-TBL_W-ENT_LG){1'b0}}, tbl_idx, {ENT_LG{1'b0}}};

  // Directory flag bits the walker does not look at
  assign dir_bits_unused = ^{mem_rdata[OFF_W-1:FLAG_USER+1]};

  ptw_entry_eval #(
    .ADDR_W (ADDR_W)
  ) u_eval (
    .dir_write  (dw_q),
    .dir_user   (du_q),
    .tbl_entry  (mem_rdata),
    .is_write   (wr_q),
    .is_user    (user_q),
    .cause      (eval_cause),
    .upd_entry  (eval_upd),
    .upd_needed (eval_needed)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    cap_req  = 1'b0;
    dir_cap  = 1'b0;
    tbl_cap  = 1'b0;
    cause_en = 1'b0;
    cause_d  = cause_q;
    tent_d   = tent_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req  = 1'b1;
          cause_en = 1'b1;
          cause_d  = CAUSE_NONE;
          pend_d   = 1'b0;
          state_d  = ST_READ_DIR;
        end
      end
      ST_READ_DIR: begin
        if (!pend_q) begin
          pend_d = 1'b1;
        end else begin
          pend_d  = 1'b0;
          dir_cap = 1'b1;
          if (!mem_rdata[FLAG_PRESENT]) begin
            cause_en = 1'b1;
            cause_d  = CAUSE_DIR_NP;
            state_d  = ST_DONE;
          end else begin
            state_d = ST_READ_PTE;
          end
        end
      end
      ST_READ_PTE: begin
        if (!pend_q) begin
          pend_d = 1'b1;
        end else begin
          pend_d  = 1'b0;
          tbl_cap = 1'b1;
          if (eval_cause != CAUSE_NONE) begin
            cause_en = 1'b1;
            cause_d  = eval_cause;
            tent_d   = mem_rdata;
            state_d  = ST_DONE;
          end else begin
            tent_d  = eval_upd;
            state_d = eval_needed ? ST_UPDATE : ST_DONE;
          end
        end
      end
      ST_UPDATE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      dfr_q   <= '0;
      dw_q    <= 1'b0;
      du_q    <= 1'b0;
      tent_q  <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (cap_req) begin
        va_q   <= req_vaddr;
        wr_q   <= req_write;
        user_q <= (cpl == RING_USER);
      end
      if (dir_cap) begin
        dfr_q <= mem_rdata[ADDR_W-1:OFF_W];
        dw_q  <= mem_rdata[FLAG_WRITE];
        du_q  <= mem_rdata[FLAG_USER];
      end
      if (tbl_cap) begin
        tent_q <= tent_d;
      end
      if (cause_en) begin
        cause_q <= cause_d;
      end
    end
  end

  // Outputs
  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (((state_q == ST_READ_DIR) || (state_q == ST_READ_PTE)) && !pend_q)
                   || (state_q == ST_UPDATE);
  assign mem_we    = (state_q == ST_UPDATE);
  assign mem_addr  = (state_q == ST_READ_DIR) ? dir_addr : tbl_addr;
  assign mem_wdata = tent_q;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_fault = (cause_q != CAUSE_NONE);
  assign rsp_cause = cause_q;
  assign rsp_paddr = (cause_q == CAUSE_NONE) ? {tent_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;

endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DIR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpl,
  input  logic              root_load,
  input  logic [ADDR_W-1:0] root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr
);

  logic [ADDR_W-1:0] root_base;

  ptw_root_reg #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_root (
    .clk         (clk),
    .rst_n       (rst_n),
    .walker_idle (req_ready),
    .cpl         (cpl),
    .load_req    (root_load),
    .load_data   (root_wdata),
    .root_q      (root_base)
  );

  ptw_walk_fsm #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .DIR_W  (DIR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .root_q    (root_base),
    .cpl       (cpl),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_write (req_write),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr)
  );

endmodule

// File: rtl/pt_walk_unit_chk.sv
module pt_walk_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cpl,
  input logic              root_load,
  input logic [ADDR_W-1:0] root_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr
);

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R3

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(mem_req && !mem_we, 2) && (mem_addr == $past(mem_addr, 2)))); // R7

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0])); // R7

  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !$past(mem_we)); // R7

  AST_ROOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (root_load && (cpl != 2'd0)) |=> $stable(root_q)); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R10

endmodule

bind pt_walk_unit pt_walk_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpl       (cpl),
  .root_load (root_load),
  .root_q    (root_base),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr)
);

// File: tb/pt_walk_unit_tb_top.sv
`timescale 1ns/1ps
module pt_walk_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cpl;
  logic        root_load;
  logic [31:0] root_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  pt_walk_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cpl(cpl), .root_load(root_load), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Memory model: 16 KB window, read data one cycle after the strobe
  logic [31:0] mem [4096];
  logic [31:0] rd_log [16];
  int          rd_cnt;
  int          wb_cnt;

  function automatic logic [31:0] init_word(input int idx);
    case (idx)
      'h401: return 32'h0000_2007;  // dir 1 -> table 0x2000, P W U
      'h402: return 32'h0000_3003;  // dir 2 -> table 0x3000, P W
      'h403: return 32'h0000_2005;  // dir 3 -> table 0x2000, P U
      'h800: return 32'h0AAA_A007;
      'h802: return 32'h0BBB_B005;
      'h803: return 32'h0CCC_C003;
      'h804: return 32'h0DDD_DE27;
      'hC05: return 32'h0EEE_E067;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= init_word(i);
      rd_cnt    <= 0;
      wb_cnt    <= 0;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wb_cnt <= wb_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_log[rd_cnt % 16] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic load_root(input logic [31:0] val, input logic [1:0] ring);
    @(negedge clk);
    root_load = 1'b1; root_wdata = val; cpl = ring;
    @(negedge clk);
    root_load = 1'b0;
  endtask

  task automatic wait_rsp(output logic [2:0] cause, output logic flt, output logic [31:0] pa);
    int n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) begin
      errors++;
      $display("FAIL R10: actual no response expected response within 100 cycles");
    end
    cause = rsp_cause; flt = rsp_fault; pa = rsp_paddr;
    @(negedge clk);
    check("R10 pulse", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic [1:0] ring,
                      output logic [2:0] cause, output logic flt, output logic [31:0] pa);
    int n = 0;
    @(negedge clk);
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b1; req_vaddr = va; req_write = wr; cpl = ring;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 busy", {31'b0, req_ready}, 32'd0);
    wait_rsp(cause, flt, pa);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  ring;
    logic [2:0]  cause;
    logic [31:0] paddr;
    logic [31:0] pte_addr;
    logic [31:0] pte_after;
    logic        wb;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_0123, 1'b0, 2'd3, 3'd0, 32'h0AAA_A123, 32'h2000, 32'h0AAA_A027, 1'b1},
    '{32'h0040_0FFF, 1'b1, 2'd3, 3'd0, 32'h0AAA_AFFF, 32'h2000, 32'h0AAA_A067, 1'b1},
    '{32'h0000_0000, 1'b0, 2'd0, 3'd1, 32'h0,         32'h2000, 32'h0AAA_A067, 1'b0},
    '{32'h0040_1000, 1'b0, 2'd0, 3'd2, 32'h0,         32'h2004, 32'h0,         1'b0},
    '{32'h0040_2010, 1'b1, 2'd3, 3'd3, 32'h0,         32'h2008, 32'h0BBB_B005, 1'b0},
    '{32'h0040_2010, 1'b0, 2'd3, 3'd0, 32'h0BBB_B010, 32'h2008, 32'h0BBB_B025, 1'b1},
    '{32'h0040_3000, 1'b0, 2'd3, 3'd4, 32'h0,         32'h200C, 32'h0CCC_C003, 1'b0},
    '{32'h0040_3456, 1'b1, 2'd0, 3'd0, 32'h0CCC_C456, 32'h200C, 32'h0CCC_C063, 1'b1},
    '{32'h00C0_0000, 1'b1, 2'd0, 3'd3, 32'h0,         32'h2000, 32'h0AAA_A067, 1'b0},
    '{32'h0080_5000, 1'b0, 2'd3, 3'd4, 32'h0,         32'h3014, 32'h0EEE_E067, 1'b0},
    '{32'h0080_5789, 1'b1, 2'd1, 3'd0, 32'h0EEE_E789, 32'h3014, 32'h0EEE_E067, 1'b0},
    '{32'h0040_400C, 1'b0, 2'd2, 3'd0, 32'h0DDD_D00C, 32'h2010, 32'h0DDD_DE27, 1'b0},
    '{32'h00C0_2000, 1'b1, 2'd3, 3'd3, 32'h0,         32'h2008, 32'h0BBB_B025, 1'b0},
    '{32'h0080_3000, 1'b0, 2'd0, 3'd2, 32'h0,         32'h300C, 32'h0,         1'b0},
    '{32'h00C0_3000, 1'b1, 2'd3, 3'd4, 32'h0,         32'h200C, 32'h0CCC_C063, 1'b0},
    '{32'h0040_4000, 1'b1, 2'd3, 3'd0, 32'h0DDD_D000, 32'h2010, 32'h0DDD_DE67, 1'b1}
  };

  function automatic string cause_req(input logic [2:0] c);
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    logic [2:0]  g_cause;
    logic        g_flt;
    logic [31:0] g_pa;
    int          rbase;
    int          wbase;
    vec_t        v;

    rst_n = 1'b0; cpl = 2'd0; root_load = 1'b0; root_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp", {31'b0, rsp_valid}, 32'd0);
    check("R1 mem", {31'b0, mem_req}, 32'd0);

    // R9: load from ring 3 ignored; root stays 0 so dir 1 reads 0x4 (empty)
    load_root(32'h0000_1000, 2'd3);
    rbase = rd_cnt;
    walk(32'h0040_0123, 1'b0, 2'd0, g_cause, g_flt, g_pa);
    check("R9 ring3 load ignored", {29'b0, g_cause}, 32'd1);
    check("R9 root still zero", rd_log[rbase % 16], 32'h0000_0004);
    check("R1 root reset", {31'b0, rd_cnt == rbase + 1}, 32'd1);

    // R9: ring 0 load with low bits dropped
    load_root(32'h0000_1FFF, 2'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      rbase = rd_cnt;
      wbase = wb_cnt;
      walk(v.va, v.wr, v.ring, g_cause, g_flt, g_pa);
      check(cause_req(v.cause), {29'b0, g_cause}, {29'b0, v.cause});
      check("R3 fault flag", {31'b0, g_flt}, {31'b0, (v.cause != 3'd0)});
      check("R3 paddr", g_pa, v.paddr);
      check("R2 dir read", rd_log[rbase % 16], 32'h1000 + {20'b0, v.va[31:22], 2'b00});
      if (v.cause == 3'd1) begin
        check("R4 no table read", rd_cnt - rbase, 32'd1);
      end else begin
        check("R2 table read", rd_log[(rbase + 1) % 16], v.pte_addr);
      end
      check("R7 R8 entry", mem[v.pte_addr[13:2]], v.pte_after);
      check("R7 writebacks", wb_cnt - wbase, {31'b0, v.wb});
    end

    // R9: root load while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0040_0123; req_write = 1'b0; cpl = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    root_load = 1'b1; root_wdata = 32'h0000_3000;
    @(negedge clk);
    root_load = 1'b0;
    wait_rsp(g_cause, g_flt, g_pa);
    rbase = rd_cnt;
    walk(32'h0040_0123, 1'b0, 2'd0, g_cause, g_flt, g_pa);
    check("R9 busy load ignored", g_pa, 32'h0AAA_A123);
    check("R9 dir base kept", rd_log[rbase % 16], 32'h0000_1004);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule